// File: doc/BRIEF.md
# Keyed Countdown Watchdog

This block is a hardware watchdog built around an 8-bit down-counter. Software arms it with a single control write. That write carries a start value for the counter, a command bit that selects start or stop, and a 7-bit key. While the watchdog runs, a free-running prescaler divides the system clock by 2^17. At 100 MHz that gives a counter step of about 763 Hz. When the counter reaches 1, a non-maskable interrupt request goes high. When it reaches 0, a one-cycle chip reset pulse is emitted.

A control write counts only if its key is the bitwise inverse of the key in the last accepted write. After reset that reference is zero, so the first good key is 0x7F, the next is 0x00, and so on. Restarting a running watchdog reloads the counter, so kicking and starting are the same operation. A write with the wrong key changes nothing except a sticky error flag. A status port shows the running flag, the current count and that error flag.

Top module: `kwdt_top`

## Requirements
- R1: After `rst_n` is released, `stat_running`, `stat_count`, `stat_key_err`, `nmi_req` and `chip_rst` are all 0.
- R2: A write is accepted only when `wr_key` equals the bitwise inverse of the key of the previous accepted write. The reference key is 0 after reset, so the first key accepted is 0x7F, then 0x00, then 0x7F, alternating.
- R3: A write with a wrong key leaves the running flag, count, interrupt and reference key unchanged, and sets `stat_key_err`. The flag stays set until `rst_n`.
- R4: An accepted start (`wr_cmd`=1) loads `wr_cnt` into the counter, sets running and restarts the prescaler. This applies whether the watchdog was stopped or already running.
- R5: While running, the count drops by exactly one every 2^DIV_W clock cycles. The first step comes 2^DIV_W cycles after the accepted start.
- R6: An accepted stop (`wr_cmd`=0) clears running and freezes the count at its current value. The `wr_cnt` field is ignored on a stop.
- R7: `nmi_req` rises one cycle after the running count becomes 1. It stays high until the next accepted write, which clears it.
- R8: Once the running count is 0, `chip_rst` pulses high for exactly one cycle, one cycle later. After that, running is 0 and every write is ignored, with no further pulse, until `rst_n`. A start with count 0 bites at once.
- R9: Command encoding: `wr_cmd`=1 means start and `wr_cmd`=0 means stop. Both require the correct key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control write strobe, one cycle per write |
| wr_cmd | input | 1 | 1 = start/kick, 0 = stop |
| wr_cnt | input | CNT_W | Start value for the counter |
| wr_key | input | KEY_W | Key that must match the rolling expected value |
| nmi_req | output | 1 | Non-maskable interrupt request level |
| chip_rst | output | 1 | One-cycle chip reset pulse |
| stat_running | output | 1 | Watchdog is counting |
| stat_count | output | CNT_W | Current counter value |
| stat_key_err | output | 1 | Sticky wrong-key flag |

## Verification
The hardest state to reach is the bitten state, together with proof that nothing can leave it. Getting there takes a correctly keyed start followed by a long stretch with no kick. Once there, a write with a valid key has to be shown to have no effect. The bench overrides the prescaler width to 3, so a step takes eight cycles. It then walks the count down from a kick and samples the exact cycles where the interrupt rises and the reset pulse appears. Finally, it issues a write with the next correct key and watches `chip_rst` for forty cycles.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
    typedef enum logic {
        CMD_STOP  = 1'b0,
        CMD_START = 1'b1
    } kwdt_cmd_e;
endpackage

// File: rtl/kwdt_prescaler.sv
module kwdt_prescaler #(
    parameter int DIV_W = 17
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic clear_i,
    output logic tick_o
);
    localparam logic [DIV_W-1:0] LAST = '1;

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } pre_st_t;

    pre_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i || !run_i) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    assign tick_o = run_i && !clear_i && (st_q.cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/kwdt_keygate.sv
module kwdt_keygate #(
    parameter int KEY_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [KEY_W-1:0] wr_key_i,
    input  logic             blocked_i,
    output logic             accept_o,
    output logic             key_err_o
);
    typedef struct packed {
        logic [KEY_W-1:0] key;
        logic             err;
    } gate_st_t;

    gate_st_t st_d, st_q;
    logic     key_ok;
    logic     live_wr;

    always_comb begin
        live_wr = wr_en_i && !blocked_i;
        key_ok  = (wr_key_i == ~st_q.key);
        st_d    = st_q;
        if (live_wr && key_ok) begin
            st_d.key = wr_key_i;
        end
        if (live_wr && !key_ok) begin
            st_d.err = 1'b1;
        end
    end

    assign accept_o  = live_wr && key_ok;
    assign key_err_o = st_q.err;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/kwdt_core.sv
module kwdt_core
    import kwdt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept_i,
    input  kwdt_cmd_e        cmd_i,
    input  logic [CNT_W-1:0] load_i,
    input  logic             tick_i,
    output logic             running_o,
    output logic [CNT_W-1:0] count_o,
    output logic             nmi_o,
    output logic             bite_o,
    output logic             bitten_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic             running;
        logic [CNT_W-1:0] cnt;
        logic             nmi;
        logic             bite;
        logic             bitten;
    } core_st_t;

    core_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.bite = 1'b0;
        if (st_q.bitten) begin
            st_d.running = 1'b0;
        end else if (accept_i) begin
            st_d.nmi = 1'b0;
            if (cmd_i == CMD_START) begin
                st_d.running = 1'b1;
                st_d.cnt     = load_i;
            end else begin
                st_d.running = 1'b0;
            end
        end else if (st_q.running) begin
            if (st_q.cnt == '0) begin
                st_d.bite    = 1'b1;
                st_d.bitten  = 1'b1;
                st_d.running = 1'b0;
            end else begin
                if (st_q.cnt == ONE) begin
                    st_d.nmi = 1'b1;
                end
                if (tick_i) begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
        end
    end

    assign running_o = st_q.running;
    assign count_o   = st_q.cnt;
    assign nmi_o     = st_q.nmi;
    assign bite_o    = st_q.bite;
    assign bitten_o  = st_q.bitten;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
    import kwdt_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int KEY_W = 7,
    parameter int DIV_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_cmd,
    input  logic [CNT_W-1:0] wr_cnt,
    input  logic [KEY_W-1:0] wr_key,
    output logic             nmi_req,
    output logic             chip_rst,
    output logic             stat_running,
    output logic [CNT_W-1:0] stat_count,
    output logic             stat_key_err
);
    logic      acc_w;
    logic      tick_w;
    logic      bitten_w;
    logic      run_w;
    kwdt_cmd_e cmd_w;

    assign cmd_w = kwdt_cmd_e'(wr_cmd);

    kwdt_keygate #(.KEY_W(KEY_W)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_key_i  (wr_key),
        .blocked_i (bitten_w),
        .accept_o  (acc_w),
        .key_err_o (stat_key_err)
    );

    kwdt_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run_w),
        .clear_i (acc_w),
        .tick_o  (tick_w)
    );

    kwdt_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept_i  (acc_w),
        .cmd_i     (cmd_w),
        .load_i    (wr_cnt),
        .tick_i    (tick_w),
        .running_o (run_w),
        .count_o   (stat_count),
        .nmi_o     (nmi_req),
        .bite_o    (chip_rst),
        .bitten_o  (bitten_w)
    );

    assign stat_running = run_w;
endmodule

// File: rtl/kwdt_checker.sv
module kwdt_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc,
    input logic             nmi_req,
    input logic             chip_rst,
    input logic             stat_running,
    input logic [CNT_W-1:0] stat_count,
    input logic             stat_key_err
);
    p_err_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stat_key_err |=> stat_key_err);

    p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_running && !acc) |=>
            (stat_count == $past(stat_count) || stat_count == $past(stat_count) - 1'b1));

    p_stop_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_running && !acc) |=> $stable(stat_count));

    p_nmi_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_req && !acc) |=> nmi_req);

    p_nmi_at_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_req) |-> ($past(stat_count) == CNT_W'(1)));

    p_bite_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        chip_rst |=> !chip_rst);

    p_bite_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        chip_rst |-> (!stat_running && stat_count == '0));
endmodule

bind kwdt_top kwdt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc          (acc_w),
    .nmi_req      (nmi_req),
    .chip_rst     (chip_rst),
    .stat_running (stat_running),
    .stat_count   (stat_count),
    .stat_key_err (stat_key_err)
);

// File: tb/kwdt_top_test.sv
module kwdt_top_test;
    localparam int NV = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_cmd = 1'b0;
    logic [7:0] wr_cnt = '0;
    logic [6:0] wr_key = '0;
    logic       nmi_req, chip_rst, stat_running, stat_key_err;
    logic [7:0] stat_count;

    int n_chk = 0;
    int n_bad = 0;

    // {key, cmd, cnt, exp_running, exp_count, exp_err}
    localparam logic [25:0] VEC [NV] = '{
        {7'h7F, 1'b1, 8'd50,  1'b1, 8'd50,  1'b0},
        {7'h00, 1'b1, 8'd60,  1'b1, 8'd60,  1'b0},
        {7'h7F, 1'b0, 8'd99,  1'b0, 8'd60,  1'b0},
        {7'h00, 1'b1, 8'd5,   1'b1, 8'd5,   1'b0},
        {7'h00, 1'b0, 8'd9,   1'b1, 8'd5,   1'b1},
        {7'h7F, 1'b0, 8'd0,   1'b0, 8'd5,   1'b1},
        {7'h7F, 1'b1, 8'd7,   1'b0, 8'd5,   1'b1},
        {7'h00, 1'b1, 8'd200, 1'b1, 8'd200, 1'b1}
    };

    kwdt_top #(.DIV_W(3)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_cmd       (wr_cmd),
        .wr_cnt       (wr_cnt),
        .wr_key       (wr_key),
        .nmi_req      (nmi_req),
        .chip_rst     (chip_rst),
        .stat_running (stat_running),
        .stat_count   (stat_count),
        .stat_key_err (stat_key_err)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wr_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // drives at a falling edge, returns half a cycle after the accepting edge
    task automatic do_write(input logic [6:0] k, input logic c, input logic [7:0] n);
        @(negedge clk);
        wr_en  = 1'b1;
        wr_key = k;
        wr_cmd = c;
        wr_cnt = n;
        @(negedge clk);
        wr_en  = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        // R1 reset state
        do_reset();
        chk("R1 status", {stat_running, stat_count, stat_key_err, nmi_req, chip_rst}, '0);

        // R2 R3 R4 R6 R9 vector walk
        for (int i = 0; i < NV; i++) begin
            do_write(VEC[i][25:19], VEC[i][18], VEC[i][17:10]);
            chk($sformatf("R2/R9 vector %0d", i),
                {stat_running, stat_count, stat_key_err}, VEC[i][9:0]);
        end

        // R2 first key after reset must be 0x7F
        do_reset();
        do_write(7'h00, 1'b1, 8'd5);
        chk("R2 first key 00 rejected", {stat_running, stat_key_err}, 2'b01);

        // R5 step timing, R7 interrupt, R8 bite
        do_reset();
        do_write(7'h7F, 1'b1, 8'd3);
        repeat (7) @(negedge clk);
        chk("R5 count before first step", stat_count, 3);
        @(negedge clk);
        chk("R5 count after first step", stat_count, 2);
        repeat (8) @(negedge clk);
        chk("R7 count 1 no nmi yet", {stat_count, nmi_req}, {8'd1, 1'b0});
        @(negedge clk);
        chk("R7 nmi rises", nmi_req, 1);
        @(negedge clk);
        chk("R7 nmi held", nmi_req, 1);
        do_write(7'h00, 1'b1, 8'd3);
        chk("R4 kick reload clears nmi", {stat_count, nmi_req, stat_running}, {8'd3, 1'b0, 1'b1});
        repeat (24) @(negedge clk);
        chk("R8 count 0 no pulse yet", {stat_count, chip_rst}, {8'd0, 1'b0});
        @(negedge clk);
        chk("R8 reset pulse", {chip_rst, stat_running}, 2'b10);
        @(negedge clk);
        chk("R8 pulse one cycle", chip_rst, 0);
        do_write(7'h7F, 1'b1, 8'd10);
        chk("R8 write ignored after bite", {stat_running, stat_count, stat_key_err}, '0);
        begin
            int pulses = 0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (chip_rst) pulses++;
            end
            chk("R8 no further pulse", pulses, 0);
        end

        // R6 stop freezes count, no bite
        do_reset();
        do_write(7'h7F, 1'b1, 8'd2);
        do_write(7'h00, 1'b0, 8'd77);
        repeat (30) @(negedge clk);
        chk("R6 stop freezes", {stat_running, stat_count, nmi_req, chip_rst}, {1'b0, 8'd2, 2'b00});

        // R7 stop clears nmi
        do_reset();
        do_write(7'h7F, 1'b1, 8'd1);
        @(negedge clk);
        chk("R7 nmi from load of 1", nmi_req, 1);
        do_write(7'h00, 1'b0, 8'd0);
        chk("R7 stop clears nmi", {nmi_req, stat_running}, 2'b00);

        // R3 wrong key while running: counting continues, reference unchanged
        do_reset();
        do_write(7'h7F, 1'b1, 8'd9);
        do_write(7'h55, 1'b0, 8'd0);
        chk("R3 wrong stop ignored", {stat_running, stat_count, stat_key_err}, {1'b1, 8'd9, 1'b1});
        do_write(7'h00, 1'b1, 8'd4);
        chk("R3 reference key kept", {stat_running, stat_count}, {1'b1, 8'd4});

        // R8 start with zero bites at once
        do_reset();
        do_write(7'h7F, 1'b1, 8'd0);
        @(negedge clk);
        chk("R8 zero start bites", chip_rst, 1);

        finish_run();
    end
endmodule